// File: doc/BRIEF.md
# Program-Counter Match Patch Unit

This unit sits beside the instruction fetch path of a small 8-bit processor that has a 16-bit address space. It lets firmware repair up to two faulty code locations held in read-only memory. Software loads a 16-bit match address for each of two slots and a control byte through a byte-wide register port.

On every opcode fetch, the unit compares the program counter with each enabled match address. On a hit, it substitutes that slot's fixed redirect vector for the fetch address. The patch routine placed at the vector later jumps back to the main program.

A single control bit moves both vectors together between a page in RAM and a page in ROM. The redirect is combinational within the fetch cycle. A hit flag and a slot number accompany each redirect, so the choice of vector can be observed.

Top module: `pc_patch_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00. Both slots are then disabled, RAM vectors are selected, and no fetch is redirected.
- R2: Register map: 0x0FF8 is slot 1 high byte, 0x0FF9 is slot 1 low byte, 0x0FFA is slot 2 high byte, 0x0FFB is slot 2 low byte, and 0x0FFC is control. A write with `reg_sel` and `reg_we` high takes effect at the clock edge. A read returns the stored value in the same cycle.
- R3: Control bit 0 enables slot 1, bit 1 enables slot 2, and bit 2 selects the redirect memory (0 = RAM, 1 = ROM). Bits 7 to 3 are not stored and read as 0.
- R4: With RAM selected, a fetch with `fetch_op` high whose PC equals an enabled slot's address yields `fetch_addr` 0x0100 for slot 1 and 0x0120 for slot 2.
- R5: With ROM selected, the same hits yield 0xF100 for slot 1 and 0xF120 for slot 2.
- R6: When `fetch_op` is low, `fetch_addr` equals `fetch_pc` and `patch_hit` is 0, whatever the address.
- R7: A slot whose enable bit is 0 never redirects, even when its address matches.
- R8: When both enabled slots match the same PC, slot 1 wins.
- R9: `patch_hit` is 1 exactly in a redirected cycle. `patch_slot` is then 1 or 2 for the winning slot and 0 in every other cycle.
- R10: Reads with `reg_sel` low or to an address outside 0x0FF8 to 0x0FFC return 0x00. Writes outside that range change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register port access strobe |
| reg_we | input | 1 | Write enable (1 = write, 0 = read) |
| reg_addr | input | 16 | Register port address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| fetch_op | input | 1 | High during an opcode fetch |
| fetch_pc | input | 16 | Program counter of the fetch |
| fetch_addr | output | 16 | Address to present to memory |
| patch_hit | output | 1 | Redirect taken this cycle |
| patch_slot | output | 2 | Winning slot number (1 or 2), 0 when no hit |

## Verification
The bench builds the unit with its default parameters: 16-bit addresses, byte registers based at 0x0FF8, vector pages at 0x0100 and 0xF100, and a 0x20 stride. These values put the exact vector addresses of both memory selections within reach of direct comparison. They also let the stimulus aim at neighbouring addresses, such as the high and low byte registers swapped or the PC off by one. A pseudo-random phase then mixes register writes, opcode and non-opcode fetches, and equal match addresses. It does this while a behavioural model predicts every output on every cycle.

// File: rtl/pc_patch_pkg.sv
// Package: shared constants and types for the PC patch unit.
// Assumes exactly two correction slots and a byte-wide register port.
package pc_patch_pkg;
    localparam int SLOTS    = 2;
    localparam int NUM_REGS = 2 * SLOTS + 1;

    // Decoded register index; slot registers first, control last.
    typedef enum logic [2:0] {
        IDX_S1_HI = 3'd0,
        IDX_S1_LO = 3'd1,
        IDX_S2_HI = 3'd2,
        IDX_S2_LO = 3'd3,
        IDX_CTRL  = 3'd4,
        IDX_NONE  = 3'd7
    } reg_idx_e;

    // Stored control bits; the upper byte bits are not kept.
    typedef struct packed {
        logic       rom_sel;
        logic [1:0] slot_en;
    } ctrl_t;
endpackage

// File: rtl/patch_regs.sv
// Module: patch_regs
// Holds the match addresses and the control bits, and serves the byte port.
// Assumes ADDR_W == 2*DATA_W so that each match address is a high/low byte pair.
module patch_regs
    import pc_patch_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_BASE = 16'h0FF8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_sel,
    input  logic                         reg_we,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic [DATA_W-1:0]            reg_rdata,
    output logic [SLOTS-1:0][ADDR_W-1:0] match_addr,
    output ctrl_t                        ctrl
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic [ADDR_W-1:0]            offset;
    reg_idx_e                     idx;
    logic [SLOTS-1:0][DATA_W-1:0] hi_q;
    logic [SLOTS-1:0][DATA_W-1:0] lo_q;
    ctrl_t                        ctrl_q;
    logic                         wr_en;

    // Decode the bus address into a register index.
    always_comb begin
        offset = reg_addr - REG_BASE;
        if (reg_addr >= REG_BASE && offset < ADDR_W'(NUM_REGS))
            idx = reg_idx_e'(offset[2:0]);
        else
            idx = IDX_NONE;
    end

    assign wr_en = reg_sel && reg_we && (idx != IDX_NONE);

    // Register update on writes; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (idx == IDX_CTRL)
                ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            else if (offset[0] == 1'b0)
                hi_q[offset[1]] <= reg_wdata;
            else
                lo_q[offset[1]] <= reg_wdata;
        end
    end

    // Read multiplexer; unmapped or unselected reads give zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            case (idx)
                IDX_S1_HI: reg_rdata = hi_q[0];
                IDX_S1_LO: reg_rdata = lo_q[0];
                IDX_S2_HI: reg_rdata = hi_q[1];
                IDX_S2_LO: reg_rdata = lo_q[1];
                IDX_CTRL:  reg_rdata = DATA_W'(ctrl_q);
                default:   reg_rdata = '0;
            endcase
        end
    end

    // Assemble full match addresses per slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_addr
        assign match_addr[s] = {hi_q[s], lo_q[s]};
    end
    assign ctrl = ctrl_q;

    // R2: control holds its value unless written.
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && reg_we && reg_addr == REG_BASE + ADDR_W'(4)) |=> $stable(ctrl_q));
    // R3: upper control bits read back as zero.
    p_ctrl_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && idx == IDX_CTRL) |-> reg_rdata[DATA_W-1:CTRL_W] == '0);
    // R10: out-of-map reads return zero.
    p_unmapped_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < REG_BASE || reg_addr > REG_BASE + ADDR_W'(NUM_REGS - 1)) |-> reg_rdata == '0);
    // R10: writes outside the map leave the slot 1 address unchanged.
    p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < REG_BASE || reg_addr > REG_BASE + ADDR_W'(NUM_REGS - 1)) |=> $stable(match_addr[0]));
endmodule

// File: rtl/patch_match.sv
// Module: patch_match
// Compares one slot's match address with the fetch PC during opcode fetches.
// Assumes the fetch strobe is high only for opcode fetches.
module patch_match #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_op,
    input  logic              slot_en,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [ADDR_W-1:0] match_addr,
    output logic              hit
);
    // Qualified equality compare.
    always_comb hit = fetch_op && slot_en && (fetch_pc == match_addr);

    // R6: no slot hit without an opcode fetch.
    p_hit_needs_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> fetch_op);
    // R7: a disabled slot never reports a hit.
    p_disabled_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |-> !hit);
endmodule

// File: rtl/patch_redirect.sv
// Module: patch_redirect
// Picks the winning slot (lowest index first) and forms the fetch address.
// Assumes vectors are evenly spaced by VEC_STRIDE from the selected page base.
module patch_redirect
    import pc_patch_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] RAM_VEC    = 16'h0100,
    parameter logic [ADDR_W-1:0] ROM_VEC    = 16'hF100,
    parameter logic [ADDR_W-1:0] VEC_STRIDE = 16'h0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [SLOTS-1:0]  slot_hit,
    input  logic              rom_sel,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              patch_hit,
    output logic [$clog2(SLOTS+1)-1:0] patch_slot
);
    localparam int SLOT_IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int SLOT_OW = $clog2(SLOTS + 1);

    logic [SLOT_IW-1:0] win;
    logic               any;
    logic [ADDR_W-1:0]  base;

    // Priority select: the lowest numbered hitting slot wins.
    always_comb begin
        win = '0;
        any = 1'b0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (slot_hit[s]) begin
                win = SLOT_IW'(s);
                any = 1'b1;
            end
        end
    end

    // Vector formation and pass-through.
    always_comb begin
        base       = rom_sel ? ROM_VEC : RAM_VEC;
        patch_hit  = any;
        patch_slot = any ? SLOT_OW'(win) + SLOT_OW'(1) : '0;
        fetch_addr = any ? base + ADDR_W'(win) * VEC_STRIDE : fetch_pc;
    end

    // R8: slot 1 wins when both slots hit.
    p_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_hit[0] && slot_hit[1]) |-> patch_slot == SLOT_OW'(1));
    // R6: no slot hit means the PC passes through.
    p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_hit == '0) |-> (fetch_addr == fetch_pc && !patch_hit));
    // R9: the slot code is non-zero exactly when a hit is flagged.
    p_slot_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        patch_hit == (patch_slot != '0));
endmodule

// File: rtl/pc_patch_unit.sv
// Module: pc_patch_unit (top)
// Redirects opcode fetches that hit a programmed address to a fixed patch vector.
// Assumes the CPU presents the opcode PC and a strobe in the same cycle it
// uses fetch_addr, and that the redirect is consumed combinationally.
module pc_patch_unit
    import pc_patch_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] REG_BASE   = 16'h0FF8,
    parameter logic [ADDR_W-1:0] RAM_VEC    = 16'h0100,
    parameter logic [ADDR_W-1:0] ROM_VEC    = 16'hF100,
    parameter logic [ADDR_W-1:0] VEC_STRIDE = 16'h0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fetch_op,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              patch_hit,
    output logic [1:0]        patch_slot
);
    logic [SLOTS-1:0][ADDR_W-1:0] match_addr;
    ctrl_t                        ctrl;
    logic [SLOTS-1:0]             slot_hit;

    patch_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .REG_BASE(REG_BASE)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .match_addr(match_addr),
        .ctrl      (ctrl)
    );

    // One comparator per slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        patch_match #(.ADDR_W(ADDR_W)) i_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .fetch_op  (fetch_op),
            .slot_en   (ctrl.slot_en[s]),
            .fetch_pc  (fetch_pc),
            .match_addr(match_addr[s]),
            .hit       (slot_hit[s])
        );
    end

    patch_redirect #(
        .ADDR_W    (ADDR_W),
        .RAM_VEC   (RAM_VEC),
        .ROM_VEC   (ROM_VEC),
        .VEC_STRIDE(VEC_STRIDE)
    ) i_redirect (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_pc  (fetch_pc),
        .slot_hit  (slot_hit),
        .rom_sel   (ctrl.rom_sel),
        .fetch_addr(fetch_addr),
        .patch_hit (patch_hit),
        .patch_slot(patch_slot)
    );

    // R6: a non-opcode access is never redirected.
    p_no_redirect_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_op |-> (fetch_addr == fetch_pc && patch_slot == 2'd0));
endmodule

// File: tb/test_pc_patch_unit.sv
`timescale 1ns/1ps
// Bench for pc_patch_unit: a behavioural register model predicts every output
// on every cycle; directed checks cover the named corner cases.
module test_pc_patch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        fetch_op = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic [15:0] fetch_addr;
    logic        patch_hit;
    logic [1:0]  patch_slot;

    int    n_tests = 0, n_fail = 0;
    bit    live = 1'b0, done = 1'b0;
    string cur_req = "R2";
    logic [7:0] mdl [5];

    always #2.5 clk = ~clk;

    pc_patch_unit i_pc_patch_unit (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fetch_op(fetch_op), .fetch_pc(fetch_pc), .fetch_addr(fetch_addr),
        .patch_hit(patch_hit), .patch_slot(patch_slot)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural model of the register state.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mdl[i]) mdl[i] <= 8'h00;
        end else if (reg_sel && reg_we && reg_addr >= 16'h0FF8 && reg_addr <= 16'h0FFC) begin
            mdl[reg_addr - 16'h0FF8] <= (reg_addr == 16'h0FFC) ? (reg_wdata & 8'h07) : reg_wdata;
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (live && rst_n) begin
            logic [7:0]  e_rd;
            logic [15:0] e_fa, base;
            logic [1:0]  e_sl;
            bit          h1, h2;
            e_rd = (reg_sel && reg_addr >= 16'h0FF8 && reg_addr <= 16'h0FFC)
                   ? mdl[reg_addr - 16'h0FF8] : 8'h00;
            h1   = fetch_op && mdl[4][0] && fetch_pc == {mdl[0], mdl[1]};
            h2   = fetch_op && mdl[4][1] && fetch_pc == {mdl[2], mdl[3]};
            base = mdl[4][2] ? 16'hF100 : 16'h0100;
            if (h1)      begin e_fa = base;           e_sl = 2'd1; end
            else if (h2) begin e_fa = base + 16'h20;  e_sl = 2'd2; end
            else         begin e_fa = fetch_pc;       e_sl = 2'd0; end
            chk(cur_req, "model rdata", reg_rdata, e_rd);
            chk(cur_req, "model fetch_addr", fetch_addr, e_fa);
            chk(cur_req, "model slot", patch_slot, e_sl);
            chk(cur_req, "model hit", patch_hit, e_sl != 2'd0);
        end
    end

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(posedge clk); #1;
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic [7:0] exp, string req);
        @(posedge clk); #1;
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        chk(req, "read", reg_rdata, exp);
        @(posedge clk); #1;
        reg_sel = 1'b0;
    endtask

    task automatic fetch(logic op, logic [15:0] pc, logic [15:0] ea, logic [1:0] es, string req);
        @(posedge clk); #1;
        fetch_op = op; fetch_pc = pc;
        @(negedge clk);
        chk(req, "fetch_addr", fetch_addr, ea);
        chk(req, "patch_slot", patch_slot, es);
        chk(req, "patch_hit", patch_hit, es != 2'd0);
        @(posedge clk); #1;
        fetch_op = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        live = 1'b1;
        // R1: reset state
        cur_req = "R1";
        rd(16'h0FF8, 8'h00, "R1"); rd(16'h0FF9, 8'h00, "R1");
        rd(16'h0FFA, 8'h00, "R1"); rd(16'h0FFB, 8'h00, "R1");
        rd(16'h0FFC, 8'h00, "R1");
        fetch(1'b1, 16'h0000, 16'h0000, 2'd0, "R1");
        // R2: map and readback
        cur_req = "R2";
        wr(16'h0FF8, 8'h81); wr(16'h0FF9, 8'h23);
        wr(16'h0FFA, 8'h9A); wr(16'h0FFB, 8'hBC);
        rd(16'h0FF8, 8'h81, "R2"); rd(16'h0FF9, 8'h23, "R2");
        rd(16'h0FFA, 8'h9A, "R2"); rd(16'h0FFB, 8'hBC, "R2");
        // R7: match but disabled
        fetch(1'b1, 16'h8123, 16'h8123, 2'd0, "R7");
        // R3: upper control bits
        cur_req = "R3";
        wr(16'h0FFC, 8'hF8);
        rd(16'h0FFC, 8'h00, "R3");
        // R4: RAM vectors
        cur_req = "R4";
        wr(16'h0FFC, 8'h03);
        rd(16'h0FFC, 8'h03, "R3");
        fetch(1'b1, 16'h8123, 16'h0100, 2'd1, "R4");
        fetch(1'b1, 16'h9ABC, 16'h0120, 2'd2, "R4");
        fetch(1'b1, 16'h2381, 16'h2381, 2'd0, "R4");
        fetch(1'b1, 16'h8124, 16'h8124, 2'd0, "R4");
        // R6: non-opcode access
        fetch(1'b0, 16'h8123, 16'h8123, 2'd0, "R6");
        fetch(1'b0, 16'h9ABC, 16'h9ABC, 2'd0, "R6");
        // R7: only slot 2 enabled
        wr(16'h0FFC, 8'h02);
        fetch(1'b1, 16'h8123, 16'h8123, 2'd0, "R7");
        fetch(1'b1, 16'h9ABC, 16'h0120, 2'd2, "R7");
        // R5: ROM vectors
        cur_req = "R5";
        wr(16'h0FFC, 8'hFF);
        rd(16'h0FFC, 8'h07, "R3");
        fetch(1'b1, 16'h8123, 16'hF100, 2'd1, "R5");
        fetch(1'b1, 16'h9ABC, 16'hF120, 2'd2, "R5");
        // R8: both slots equal
        cur_req = "R8";
        wr(16'h0FFA, 8'h81); wr(16'h0FFB, 8'h23);
        fetch(1'b1, 16'h8123, 16'hF100, 2'd1, "R8");
        wr(16'h0FFC, 8'h06);
        fetch(1'b1, 16'h8123, 16'hF120, 2'd2, "R8");
        // R10: unmapped accesses
        cur_req = "R10";
        wr(16'h0FF7, 8'h55); wr(16'h0FFD, 8'h66);
        rd(16'h0FF7, 8'h00, "R10"); rd(16'h0FFD, 8'h00, "R10");
        rd(16'h0FF8, 8'h81, "R10"); rd(16'h0FFC, 8'h06, "R10");
        @(posedge clk); #1 reg_sel = 1'b0; reg_addr = 16'h0FF8;
        @(negedge clk); chk("R10", "unselected read", reg_rdata, 8'h00);
        // R9: random mix, compared each cycle by the model
        cur_req = "R9";
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            reg_sel = (lf[3:0] == 4'h0);
            reg_we  = lf[4];
            reg_addr = 16'h0FF6 + 16'(lf[7:5]);
            reg_wdata = lf[15:8];
            fetch_op = lf[8];
            case (lf[10:9])
                2'd0: fetch_pc = {mdl[0], mdl[1]};
                2'd1: fetch_pc = {mdl[2], mdl[3]};
                2'd2: fetch_pc = {mdl[0], mdl[1]} + 16'd1;
                default: fetch_pc = lf;
            endcase
        end
        @(posedge clk); #1;
        reg_sel = 1'b0; fetch_op = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule